// File: doc/BRIEF.md
# Asynchronous Character Receiver with Break Detection

This block takes an asynchronous serial line (idle high, one start bit low, data least significant bit first, one stop bit high) and turns each character into a parallel data word. It presents the word to a downstream FIFO as a single-cycle write strobe. Timing comes from an enable tick supplied at 16 times the bit rate, so the block runs at any asynchronous rate, up to 128 kbps and beyond, for which a suitable tick is provided. One select input picks a word length of 8 or 9 data bits.

The block rejects start bits that do not persist to the middle of the bit. It classifies every completed character as one of four outcomes: a good word, a word dropped because the FIFO is full, a framing error, or a line break. A break is a character in which every data bit and the stop bit sample low. It is reported as a level flag to the downstream synchronous transmitter, not as a character. While the break flag is up, no new characters are started. The flag drops once the line has been high for one full bit time.

Top module: `async_char_stripper`

## Requirements
- R1: After reset, wr_o, overrun_o and frame_err_o are low, break_o is low and the receiver is idle.
- R2: With len9_i low, a character of 8 data bits sent least significant bit first produces one wr_o pulse, with the bits in wr_data_o[7:0] and wr_data_o[8] = 0.
- R3: With len9_i high, a character of 9 data bits produces one wr_o pulse with all nine bits in wr_data_o[8:0], least significant bit in bit 0.
- R4: The start bit is re-sampled at the 8th tick after the falling edge. A low pulse shorter than half a bit produces no wr_o, overrun_o or frame_err_o.
- R5: If fifo_full_i is high when a good character completes, no wr_o is issued and overrun_o pulses for one cycle.
- R6: A character whose stop bit samples low while its data is not all zeros gives a one-cycle frame_err_o pulse and no wr_o.
- R7: A character whose data bits and stop bit all sample low raises break_o and gives neither wr_o nor frame_err_o.
- R8: break_o stays high while the line is low. It clears only after 16 consecutive high ticks (one bit time). No character is started while it is high.
- R9: wr_o, overrun_o and frame_err_o are single-cycle pulses, and at most one of them is high in any cycle.
- R10: Characters sent back to back, each with a single stop bit, are all received in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | Enable pulse at 16 times the bit rate |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| len9_i | input | 1 | Word length select: 1 = 9 data bits, 0 = 8 |
| fifo_full_i | input | 1 | Downstream FIFO full |
| wr_o | output | 1 | One-cycle write strobe for a good character |
| wr_data_o | output | 9 | Received word, bit 0 first on the line |
| overrun_o | output | 1 | One-cycle pulse: character dropped, FIFO full |
| frame_err_o | output | 1 | One-cycle pulse: low stop bit on a non-zero character |
| break_o | output | 1 | Line break condition, level |

## Verification
The assertions check on every cycle the rules about pulse shape and exclusivity. They check that no write happens while the FIFO is full, that in 8-bit mode the top data bit is zero, and that a write never coincides with the break flag rising. They also check that the break flag falls only after the synchronized line was high. The bench's scenarios are needed to show the rest: the bit order and values of received words in both lengths, the rejection of a short start glitch, the classification of framing errors against breaks, and the break hold time and release followed by a normal character. Back-to-back reception also needs the scenarios.

// File: rtl/acs_pkg.sv
package acs_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/acs_sync.sv
module acs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/acs_rx_fsm.sv
module acs_rx_fsm
  import acs_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int WORD_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              len9_i,
  input  logic              hold_i,
  output logic              done_o,
  output logic              stop_o,
  output logic [WORD_W-1:0] data_o,
  output logic              len9_q_o
);
  localparam int CW      = $clog2(OVS);
  localparam int BW      = $clog2(WORD_W);
  // first START tick is sample 2 of the start bit
  localparam int MID_CNT = OVS/2 - 2;

  rx_state_e         st_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bidx_q;
  logic [WORD_W-1:0] sh_q;
  logic              len9_q;
  logic              stop_q;
  logic              done_q;
  logic [BW-1:0]     last_idx;

  assign last_idx = len9_q ? BW'(WORD_W-1) : BW'(WORD_W-2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bidx_q <= '0;
      sh_q   <= '0;
      len9_q <= 1'b0;
      stop_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          RX_IDLE: begin
            if (!hold_i && !rxd_i) begin
              st_q  <= RX_START;
              cnt_q <= '0;
            end
          end
          RX_START: begin
            if (cnt_q == CW'(MID_CNT)) begin
              if (rxd_i) begin
                st_q <= RX_IDLE;
              end else begin
                st_q   <= RX_DATA;
                cnt_q  <= '0;
                bidx_q <= '0;
                sh_q   <= '0;
                len9_q <= len9_i;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt_q == CW'(OVS-1)) begin
              cnt_q <= '0;
              sh_q  <= {rxd_i, sh_q[WORD_W-1:1]};
              if (bidx_q == last_idx) st_q <= RX_STOP;
              else                    bidx_q <= bidx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt_q == CW'(OVS-1)) begin
              cnt_q  <= '0;
              st_q   <= RX_IDLE;
              stop_q <= rxd_i;
              done_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  // short words land in the upper bits of the shift register
  assign data_o   = len9_q ? sh_q : {1'b0, sh_q[WORD_W-1:1]};
  assign done_o   = done_q;
  assign stop_o   = stop_q;
  assign len9_q_o = len9_q;
endmodule

// File: rtl/acs_break_det.sv
module acs_break_det #(
  parameter int OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rxd_i,
  input  logic set_i,
  output logic brk_o
);
  localparam int CW = $clog2(OVS);

  logic          brk_q;
  logic [CW-1:0] hcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_q  <= 1'b0;
      hcnt_q <= '0;
    end else if (set_i) begin
      brk_q  <= 1'b1;
      hcnt_q <= '0;
    end else if (brk_q && tick_i) begin
      if (!rxd_i) begin
        hcnt_q <= '0;
      end else if (hcnt_q == CW'(OVS-1)) begin
        brk_q  <= 1'b0;
        hcnt_q <= '0;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  assign brk_o = brk_q;
endmodule

// File: rtl/acs_classify.sv
module acs_classify #(
  parameter int WORD_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              stop_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              full_i,
  output logic              wr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              ovr_o,
  output logic              ferr_o,
  output logic              brk_set_o
);
  logic zero;
  logic wr_q, ovr_q, ferr_q;
  logic [WORD_W-1:0] data_q;

  assign zero      = (data_i == '0);
  assign brk_set_o = done_i && !stop_i && zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      ovr_q  <= 1'b0;
      ferr_q <= 1'b0;
      data_q <= '0;
    end else begin
      wr_q   <= done_i && stop_i && !full_i;
      ovr_q  <= done_i && stop_i && full_i;
      ferr_q <= done_i && !stop_i && !zero;
      if (done_i && stop_i && !full_i) data_q <= data_i;
    end
  end

  assign wr_o      = wr_q;
  assign wr_data_o = data_q;
  assign ovr_o     = ovr_q;
  assign ferr_o    = ferr_q;
endmodule

// File: rtl/async_char_stripper.sv
module async_char_stripper #(
  parameter int OVS         = 16,
  parameter int WORD_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              rxd_i,
  input  logic              len9_i,
  input  logic              fifo_full_i,
  output logic              wr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              overrun_o,
  output logic              frame_err_o,
  output logic              break_o
);
  logic              rxd_s;
  logic              done;
  logic              stop_bit;
  logic [WORD_W-1:0] word;
  logic              len9_q;
  logic              brk_set;

  acs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  acs_rx_fsm #(.OVS(OVS), .WORD_W(WORD_W)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick16_i),
    .rxd_i   (rxd_s),
    .len9_i  (len9_i),
    .hold_i  (break_o),
    .done_o  (done),
    .stop_o  (stop_bit),
    .data_o  (word),
    .len9_q_o(len9_q)
  );

  acs_classify #(.WORD_W(WORD_W)) u_cls (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done),
    .stop_i   (stop_bit),
    .data_i   (word),
    .full_i   (fifo_full_i),
    .wr_o     (wr_o),
    .wr_data_o(wr_data_o),
    .ovr_o    (overrun_o),
    .ferr_o   (frame_err_o),
    .brk_set_o(brk_set)
  );

  acs_break_det #(.OVS(OVS)) u_brk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick16_i),
    .rxd_i (rxd_s),
    .set_i (brk_set),
    .brk_o (break_o)
  );
endmodule

// File: rtl/acs_checker.sv
module acs_checker #(
  parameter int WORD_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [WORD_W-1:0] data_i,
  input logic              ovr_i,
  input logic              ferr_i,
  input logic              brk_i,
  input logic              full_i,
  input logic              len9_q_i,
  input logic              rxd_s_i
);
  assert_one_event_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_i, ovr_i, ferr_i}));

  assert_wr_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !wr_i);

  assert_ferr_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_i |=> !ferr_i);

  assert_ovr_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i |=> !ovr_i);

  assert_no_wr_when_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !$past(full_i));

  assert_short_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !len9_q_i) |-> (data_i[WORD_W-1] == 1'b0));

  assert_break_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_i) |-> (!wr_i && !ferr_i));

  assert_break_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(brk_i) |-> $past(rxd_s_i));
endmodule

bind async_char_stripper acs_checker #(.WORD_W(WORD_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_o),
  .data_i  (wr_data_o),
  .ovr_i   (overrun_o),
  .ferr_i  (frame_err_o),
  .brk_i   (break_o),
  .full_i  (fifo_full_i),
  .len9_q_i(len9_q),
  .rxd_s_i (rxd_s)
);

// File: tb/async_char_stripper_tb.sv
`timescale 1ns/1ps
module async_char_stripper_tb;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 16 * TICK_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rxd = 1'b1;
  logic len9 = 1'b0;
  logic full = 1'b0;
  logic wr, ovr, ferr, brk;
  logic [8:0] wdata;

  int n_chk = 0, n_err = 0;
  int wr_cnt = 0, ovr_cnt = 0, fe_cnt = 0;
  logic [8:0] hist0 = '0, hist1 = '0;
  bit finished = 0;
  int div_q = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    div_q <= (div_q == TICK_DIV-1) ? 0 : div_q + 1;
    tick  <= (div_q == TICK_DIV-1);
  end

  async_char_stripper u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .rxd_i(rxd),
    .len9_i(len9), .fifo_full_i(full), .wr_o(wr), .wr_data_o(wdata),
    .overrun_o(ovr), .frame_err_o(ferr), .break_o(brk)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr) begin wr_cnt++; hist1 = hist0; hist0 = wdata; end
      if (ovr) ovr_cnt++;
      if (ferr) fe_cnt++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int nbits, input logic stop_v, input int idle_bits);
    drive_bit(1'b0);
    for (int i = 0; i < nbits; i++) drive_bit(d[i]);
    rxd = stop_v;
    if (stop_v) repeat (BIT_CLK) @(negedge clk);
    else begin repeat (40) @(negedge clk); rxd = 1'b1; repeat (BIT_CLK-40) @(negedge clk); end
    for (int i = 0; i < idle_bits; i++) drive_bit(1'b1);
  endtask

  task automatic t_reset();
    check("R1 wr", wr, 0);
    check("R1 overrun", ovr, 0);
    check("R1 frame_err", ferr, 0);
    check("R1 break", brk, 0);
  endtask

  task automatic t_len8();
    int w0;
    len9 = 1'b0; w0 = wr_cnt;
    send(9'h0A5, 8, 1'b1, 2);
    check("R2 count", wr_cnt - w0, 1);
    check("R2 data", hist0, 9'h0A5);
    send(9'h0FE, 8, 1'b1, 2);
    check("R2 data high bit clear", hist0, 9'h0FE);
  endtask

  task automatic t_len9();
    int w0;
    len9 = 1'b1; w0 = wr_cnt;
    send(9'h1C3, 9, 1'b1, 2);
    check("R3 count", wr_cnt - w0, 1);
    check("R3 data", hist0, 9'h1C3);
    len9 = 1'b0;
  endtask

  task automatic t_false_start();
    int w0, f0, o0;
    w0 = wr_cnt; f0 = fe_cnt; o0 = ovr_cnt;
    rxd = 1'b0; repeat (5 * TICK_DIV) @(negedge clk);
    rxd = 1'b1; repeat (12 * BIT_CLK) @(negedge clk);
    check("R4 no write", wr_cnt - w0, 0);
    check("R4 no error", (fe_cnt - f0) + (ovr_cnt - o0), 0);
    send(9'h03C, 8, 1'b1, 2);
    check("R4 next char ok", hist0, 9'h03C);
  endtask

  task automatic t_overrun();
    int w0, o0;
    w0 = wr_cnt; o0 = ovr_cnt; full = 1'b1;
    send(9'h011, 8, 1'b1, 2);
    full = 1'b0;
    check("R5 no write", wr_cnt - w0, 0);
    check("R5 overrun pulse", ovr_cnt - o0, 1);
  endtask

  task automatic t_frame();
    int w0, f0;
    w0 = wr_cnt; f0 = fe_cnt;
    send(9'h081, 8, 1'b0, 3);
    check("R6 frame_err pulse", fe_cnt - f0, 1);
    check("R6 no write", wr_cnt - w0, 0);
    check("R6 no break", brk, 0);
  endtask

  task automatic t_break();
    int w0, f0;
    w0 = wr_cnt; f0 = fe_cnt;
    rxd = 1'b0;
    repeat (12 * BIT_CLK) @(negedge clk);
    check("R7 break set", brk, 1);
    check("R7 no write", wr_cnt - w0, 0);
    check("R7 no frame_err", fe_cnt - f0, 0);
    repeat (20 * BIT_CLK) @(negedge clk);
    check("R8 held while low", brk, 1);
    check("R8 no chars while held", (wr_cnt - w0) + (fe_cnt - f0), 0);
    rxd = 1'b1;
    repeat (8 * TICK_DIV) @(negedge clk);
    check("R8 held after half bit high", brk, 1);
    repeat (12 * TICK_DIV) @(negedge clk);
    check("R8 released after bit time", brk, 0);
    drive_bit(1'b1);
    send(9'h05A, 8, 1'b1, 2);
    check("R8 char after break", hist0, 9'h05A);
  endtask

  task automatic t_back_to_back();
    int w0;
    w0 = wr_cnt;
    send(9'h03C, 8, 1'b1, 0);
    send(9'h0F0, 8, 1'b1, 2);
    check("R10 count", wr_cnt - w0, 2);
    check("R10 order", {hist1, hist0}, {9'h03C, 9'h0F0});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
    t_len8();
    t_len9();
    t_false_start();
    t_overrun();
    t_frame();
    t_break();
    t_back_to_back();
    finish_run();
  end
endmodule